// File: doc/BRIEF.md
# Lockable Watchdog Timer with Keyed Service

This block is a system watchdog placed on a simple synchronous register bus. Software writes a control word that sets the reload count, the expiry action and the prescaler. It then has to keep the down-counter from reaching zero by writing an ordered pair of key values to the service register. If the counter runs out, the block sends a single-cycle reset request to the system reset logic or raises a level interrupt, depending on the selected mode. A sticky status bit records that a reset request was issued, and software clears it by writing one to it.

After power-on reset only one control write may decide the enable bit, the expiry mode and the reload count. Every later write leaves those three fields unchanged. Software reads the control register back to see what is actually in force, for example to find out that an attempt to enable the watchdog came too late. The freeze and prescale bits can be written at any time. With freeze set, an external debug-halt input stops the count.

Top module: `sys_wdog`

## Requirements
- R1: After reset, the control word at byte offset 0x4 reads 0xFFFF0003. Its layout is reload count [31:16], freeze [3], enable [2], mode [1] (1 = reset request, 0 = interrupt) and prescale [0]. The count register at 0x8 reads 0x0000FFFF, the status register at 0x10 reads 0, and an unused offset such as 0x0 reads 0. Read data is registered and appears one cycle after the address.
- R2: The first control write after reset sets the reload count, the enable bit and the mode, and a read of the control register returns those values.
- R3: After that first write, the enable bit, the mode and the reload count ignore further writes. Freeze and prescale stay writable.
- R4: If the first write leaves enable clear, enable can never be set afterwards. The count then stays equal to the reload count and never expires.
- R5: Writing 0x556C and then 0xAA39 to the service register reloads the counter with the reload count on the edge of the second write. The service register is at byte offset 0xE: data bits [31:16], with byte strobes 3 and 2 both set.
- R6: The pair does not reload the counter if either word is wrong or out of order. Any other value after 0x556C returns the sequence to idle, so 0x556C has to be written again.
- R7: With prescale clear, the counter steps down once per clock. With prescale set, it steps down once every PRE_DIV clocks. A step taken at zero is an expiry, and the counter reloads, so one period is reload count + 1 steps.
- R8: In reset mode an expiry produces a reset request pulse exactly one cycle long. It appears reload count + 2 cycles after the edge of the enabling control write.
- R9: In interrupt mode an expiry raises the interrupt, which stays high until a valid service pair completes. The interrupt is never high in reset mode.
- R10: The counter holds its value while freeze is set and the debug-halt input is high. Freeze alone or halt alone does not stop it.
- R11: The status bit (bit 0 at 0x10) is set in the cycle after a reset request pulse. Writing 1 to that bit clears it.
- R12: Writes to the count register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dbg_halt | input | 1 | Debug halt request |
| wd_rst_req | output | 1 | One-cycle reset request |
| wd_irq | output | 1 | Level interrupt on expiry |

## Verification
A read returns its value one cycle after the address is presented. A service or count change is visible on the edge of the write that causes it. An expiry takes reload count + 1 steps after the reload, and in reset mode a step lands reload count + 2 cycles after the enabling write. The status bit follows the pulse by one more cycle. The bench drives every input on the falling edge and calls its write and read tasks back to back. It counts each wait in rising edges from the write edge, and it samples on the falling edge just before and just after the edge on which each result is due. This brackets the pulse timing, the interrupt timing and the prescaled expiry edge exactly.

// File: rtl/sys_wdog_pkg.sv
package sys_wdog_pkg;
  localparam int TC_W = 16;
  localparam logic [TC_W-1:0] KEY_FIRST  = 16'h556C;
  localparam logic [TC_W-1:0] KEY_SECOND = 16'hAA39;
  localparam int CTRL_WORD = 1;
  localparam int CNT_WORD  = 2;
  localparam int SVC_WORD  = 3;
  localparam int STAT_WORD = 4;

  typedef enum logic {SVC_IDLE, SVC_ARMED} svc_state_e;

  typedef struct packed {
    logic [TC_W-1:0] tc;
    logic            frz;
    logic            en;
    logic            mode;
    logic            pre;
  } ctrl_t;
endpackage

// File: rtl/sys_wdog_regs.sv
module sys_wdog_regs
  import sys_wdog_pkg::*;
#(
  parameter logic EN_RST = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_ctrl,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output ctrl_t       ctrl,
  output logic        locked,
  output logic        load_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl.tc    <= '1;
      ctrl.frz   <= 1'b0;
      ctrl.en    <= EN_RST;
      ctrl.mode  <= 1'b1;
      ctrl.pre   <= 1'b1;
      locked     <= 1'b0;
      load_pulse <= 1'b0;
    end else begin
      load_pulse <= 1'b0;
      if (wr_ctrl) begin
        if (!locked) begin
          if (be[3]) ctrl.tc[15:8] <= wdata[31:24];
          if (be[2]) ctrl.tc[7:0]  <= wdata[23:16];
          if (be[0]) begin
            ctrl.en   <= wdata[2];
            ctrl.mode <= wdata[1];
          end
          locked     <= 1'b1;
          load_pulse <= 1'b1;
        end
        if (be[0]) begin
          ctrl.frz <= wdata[3];
          ctrl.pre <= wdata[0];
        end
      end
    end
  end
endmodule

// File: rtl/sys_wdog_svc.sv
module sys_wdog_svc
  import sys_wdog_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_svc,
  input  logic [TC_W-1:0] key,
  output logic            svc_reload
);
  svc_state_e state;

  assign svc_reload = wr_svc && (state == SVC_ARMED) && (key == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SVC_IDLE;
    end else if (wr_svc) begin
      if (state == SVC_IDLE && key == KEY_FIRST) state <= SVC_ARMED;
      else                                       state <= SVC_IDLE;
    end
  end
endmodule

// File: rtl/sys_wdog_cnt.sv
module sys_wdog_cnt
  import sys_wdog_pkg::*;
#(
  parameter int PRE_DIV = 65536
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            pre_en,
  input  logic            frz,
  input  logic            dbg_halt,
  input  logic            mode,
  input  logic            load,
  input  logic            svc_reload,
  input  logic [TC_W-1:0] tc,
  output logic [TC_W-1:0] cnt,
  output logic            rst_req,
  output logic            irq
);
  logic frozen, reload, wrap, tick, expire;

  assign frozen = frz && dbg_halt;
  assign reload = load || svc_reload;

  generate
    if (PRE_DIV > 1) begin : g_pre
      localparam int PRE_W = $clog2(PRE_DIV);
      logic [PRE_W-1:0] pre_cnt;
      assign wrap = (pre_cnt == PRE_W'(PRE_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || reload || !en)  pre_cnt <= '0;
        else if (pre_en && !frozen) pre_cnt <= wrap ? '0 : pre_cnt + 1'b1;
      end
    end else begin : g_nopre
      assign wrap = 1'b1;
    end
  endgenerate

  assign tick   = en && !frozen && !reload && (!pre_en || wrap);
  assign expire = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '1;
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rst_req <= expire && mode;
      if (reload || !en || expire) cnt <= tc;
      else if (tick)               cnt <= cnt - 1'b1;
      if (svc_reload)              irq <= 1'b0;
      else if (expire && !mode)    irq <= 1'b1;
    end
  end
endmodule

// File: rtl/sys_wdog.sv
module sys_wdog
  import sys_wdog_pkg::*;
#(
  parameter int   ADDR_W  = 5,
  parameter int   PRE_DIV = 65536,
  parameter logic EN_RST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dbg_halt,
  output logic              wd_rst_req,
  output logic              wd_irq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              wr_ctrl, wr_svc, wr_stat;
  ctrl_t             ctrl;
  logic              ctrl_locked, load_pulse, svc_reload, stat_flag;
  logic [TC_W-1:0]   cnt_val, ctrl_tc;
  logic              ctrl_en, ctrl_mode, ctrl_frz, ctrl_pre;
  logic              unused_bits;

  assign word        = bus_addr[ADDR_W-1:2];
  assign wr_ctrl     = bus_we && (word == WORD_W'(CTRL_WORD));
  assign wr_svc      = bus_we && (word == WORD_W'(SVC_WORD)) && (&bus_be[3:2]);
  assign wr_stat     = bus_we && (word == WORD_W'(STAT_WORD)) && bus_be[0] && bus_wdata[0];
  assign unused_bits = ^{bus_addr[1:0], bus_be[1], bus_wdata[15:4]};

  assign ctrl_tc   = ctrl.tc;
  assign ctrl_en   = ctrl.en;
  assign ctrl_mode = ctrl.mode;
  assign ctrl_frz  = ctrl.frz;
  assign ctrl_pre  = ctrl.pre;

  sys_wdog_regs #(.EN_RST(EN_RST)) regs_i (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .be(bus_be), .wdata(bus_wdata),
    .ctrl(ctrl), .locked(ctrl_locked), .load_pulse(load_pulse)
  );

  sys_wdog_svc svc_i (
    .clk(clk), .rst(rst), .wr_svc(wr_svc), .key(bus_wdata[31:16]),
    .svc_reload(svc_reload)
  );

  sys_wdog_cnt #(.PRE_DIV(PRE_DIV)) cnt_i (
    .clk(clk), .rst(rst), .en(ctrl_en), .pre_en(ctrl_pre), .frz(ctrl_frz),
    .dbg_halt(dbg_halt), .mode(ctrl_mode), .load(load_pulse),
    .svc_reload(svc_reload), .tc(ctrl_tc), .cnt(cnt_val),
    .rst_req(wd_rst_req), .irq(wd_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)             stat_flag <= 1'b0;
    else if (wd_rst_req) stat_flag <= 1'b1;
    else if (wr_stat)    stat_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (word == WORD_W'(CTRL_WORD))
        bus_rdata <= {ctrl_tc, 12'h000, ctrl_frz, ctrl_en, ctrl_mode, ctrl_pre};
      else if (word == WORD_W'(CNT_WORD))
        bus_rdata <= {16'h0000, cnt_val};
      else if (word == WORD_W'(STAT_WORD))
        bus_rdata <= {31'h0, stat_flag};
    end
  end
endmodule

// File: rtl/sys_wdog_chk.sv
module sys_wdog_chk (
  input logic        clk,
  input logic        rst,
  input logic        wd_rst_req,
  input logic        wd_irq,
  input logic        svc_reload,
  input logic        load_pulse,
  input logic        ctrl_en,
  input logic        ctrl_mode,
  input logic        ctrl_frz,
  input logic        ctrl_pre,
  input logic        ctrl_locked,
  input logic        dbg_halt,
  input logic [15:0] cnt_val,
  input logic [15:0] ctrl_tc,
  input logic        stat_flag
);
  p_pulse_one_r8: assert property (@(posedge clk) disable iff (rst)
    wd_rst_req |=> !wd_rst_req);

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (wd_irq && !svc_reload) |=> wd_irq);

  p_irq_mode_r9: assert property (@(posedge clk) disable iff (rst)
    wd_irq |-> !ctrl_mode);

  p_lock_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_locked |=> ($stable(ctrl_en) && $stable(ctrl_mode) && $stable(ctrl_tc)));

  p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_frz && dbg_halt && !svc_reload && !load_pulse) |=> $stable(cnt_val));

  p_step_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && !ctrl_pre && !(ctrl_frz && dbg_halt) && !svc_reload &&
     !load_pulse && cnt_val != 16'd0) |=> (cnt_val == $past(cnt_val) - 16'd1));

  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    svc_reload |=> (cnt_val == $past(ctrl_tc)));

  p_stat_set_r11: assert property (@(posedge clk) disable iff (rst)
    wd_rst_req |=> stat_flag);
endmodule

bind sys_wdog sys_wdog_chk chk_i (
  .clk(clk), .rst(rst), .wd_rst_req(wd_rst_req), .wd_irq(wd_irq),
  .svc_reload(svc_reload), .load_pulse(load_pulse), .ctrl_en(ctrl_en),
  .ctrl_mode(ctrl_mode), .ctrl_frz(ctrl_frz), .ctrl_pre(ctrl_pre),
  .ctrl_locked(ctrl_locked), .dbg_halt(dbg_halt), .cnt_val(cnt_val),
  .ctrl_tc(ctrl_tc), .stat_flag(stat_flag)
);

// File: tb/sys_wdog_tb_top.sv
module sys_wdog_tb_top;
  localparam int PRE_DIV = 16;
  localparam int N_VEC   = 6;
  // Each row is {first word, second word, third word, reload expected}.
  localparam logic [48:0] SVC_VEC [N_VEC] = '{
    {16'h0000, 16'h556C, 16'hAA39, 1'b1},
    {16'hAA39, 16'h556C, 16'h1111, 1'b0},
    {16'h556C, 16'h556C, 16'hAA39, 1'b0},
    {16'h556C, 16'h1111, 16'hAA39, 1'b0},
    {16'h1234, 16'h0000, 16'hAA39, 1'b0},
    {16'hAA39, 16'h556C, 16'hAA39, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        wd_rst_req, wd_irq;
  int          nchk = 0;
  int          nfail = 0;
  logic [31:0] rv, va, vb;

  always #5 clk = ~clk;

  sys_wdog #(.ADDR_W(5), .PRE_DIV(PRE_DIV), .EN_RST(1'b0)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .wd_rst_req(wd_rst_req), .wd_irq(wd_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_addr = a; bus_we = 1'b1; bus_be = be; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic svc(input logic [15:0] k);
    wr(5'h0C, {k, 16'h0000}, 4'b1100);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(5'h04, rv); check("R1 ctrl reset", rv, 32'hFFFF0003);
    rd(5'h08, rv); check("R1 count reset", rv, 32'h0000FFFF);
    rd(5'h10, rv); check("R1 status reset", rv, 32'h0);
    rd(5'h00, rv); check("R1 reserved", rv, 32'h0);
    check("R1 outputs idle", {30'h0, wd_rst_req, wd_irq}, 32'h0);

    // R2 / R3 lock: tc=200, interrupt mode, enabled, no prescale
    wr(5'h04, 32'h00C8_0004, 4'hF);
    rd(5'h04, rv); check("R2 first write", rv, 32'h00C8_0004);
    wr(5'h04, 32'h0030_000B, 4'hF);
    rd(5'h04, rv); check("R3 locked fields", rv, 32'h00C8_000D);
    wr(5'h04, 32'h0000_0000, 4'hF);
    rd(5'h04, rv); check("R3 freeze/prescale writable", rv, 32'h00C8_0004);

    // R5 / R6 service sequences from the vector table
    for (int i = 0; i < N_VEC; i++) begin
      svc(16'h0000); svc(16'h556C); svc(16'hAA39);
      repeat (10) @(posedge clk);
      @(negedge clk);
      svc(SVC_VEC[i][48:33]); svc(SVC_VEC[i][32:17]); svc(SVC_VEC[i][16:1]);
      rd(5'h08, rv);
      if (SVC_VEC[i][0]) check($sformatf("R5 vector %0d", i), rv, 32'd200);
      else check($sformatf("R6 vector %0d", i), {31'h0, rv == 32'd200}, 32'h0);
    end

    // R10 freeze with halt, R12 count write ignored
    svc(16'h556C); svc(16'hAA39);
    wr(5'h04, 32'h0000_0008, 4'hF);
    dbg_halt = 1'b1;
    rd(5'h08, va);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(5'h08, vb); check("R10 frozen", vb, va);
    wr(5'h08, 32'h0000_1234, 4'hF);
    rd(5'h08, vb); check("R12 count write ignored", vb, va);
    dbg_halt = 1'b0;
    rd(5'h08, va);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(5'h08, vb); check("R10 R7 freeze without halt counts", vb, va - 32'd11);
    wr(5'h04, 32'h0000_0000, 4'hF);
    dbg_halt = 1'b1;
    rd(5'h08, va);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(5'h08, vb); check("R10 halt without freeze counts", vb, va - 32'd11);
    dbg_halt = 1'b0;

    // R9 interrupt mode
    svc(16'h556C); svc(16'hAA39);
    repeat (200) @(posedge clk);
    @(negedge clk); check("R9 irq before expiry", {31'h0, wd_irq}, 32'h0);
    @(posedge clk);
    @(negedge clk); check("R9 irq at expiry", {31'h0, wd_irq}, 32'h1);
    repeat (30) @(posedge clk);
    @(negedge clk); check("R9 irq held", {31'h0, wd_irq}, 32'h1);
    svc(16'h556C); check("R9 irq held after first key", {31'h0, wd_irq}, 32'h1);
    svc(16'hAA39); check("R9 irq cleared by service", {31'h0, wd_irq}, 32'h0);

    // R8 / R11 reset mode, tc=5, no prescale
    do_reset();
    wr(5'h04, 32'h0005_0006, 4'hF);
    repeat (6) @(posedge clk);
    @(negedge clk); check("R8 no pulse early", {31'h0, wd_rst_req}, 32'h0);
    @(posedge clk);
    @(negedge clk); check("R8 pulse due", {31'h0, wd_rst_req}, 32'h1);
    @(posedge clk);
    @(negedge clk); check("R8 pulse one cycle", {31'h0, wd_rst_req}, 32'h0);
    rd(5'h10, rv); check("R11 status set", rv, 32'h1);
    wr(5'h10, 32'h1, 4'hF);
    rd(5'h10, rv); check("R11 status cleared", rv, 32'h0);

    // R4 enable left clear stays clear
    do_reset();
    wr(5'h04, 32'h0005_0002, 4'hF);
    wr(5'h04, 32'h0005_0006, 4'hF);
    rd(5'h04, rv); check("R4 enable not taken", rv, 32'h0005_0002);
    repeat (20) @(posedge clk);
    @(negedge clk);
    rd(5'h08, rv); check("R4 count held", rv, 32'h5);
    check("R4 no expiry", {31'h0, wd_rst_req}, 32'h0);

    // R7 prescaled expiry: tc=3, PRE_DIV=16, reset mode
    do_reset();
    wr(5'h04, 32'h0003_0007, 4'hF);
    repeat (64) @(posedge clk);
    @(negedge clk); check("R7 prescaled before expiry", {31'h0, wd_rst_req}, 32'h0);
    @(posedge clk);
    @(negedge clk); check("R7 prescaled expiry", {31'h0, wd_rst_req}, 32'h1);

    summary();
    $finish;
  end
endmodule